// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

A single-channel engine that moves bytes between an I/O device and memory without the processor touching each byte. Software first programs a start address, a byte count and a mode word. A device request then makes the channel ask the processor for the system bus through a hold/acknowledge handshake. After the grant, the channel acknowledges the device and runs one fixed three-cycle memory slot per byte. When the count is exhausted it gives the bus back.

The memory side is a plain strobe interface rather than a valid/ready stream. No data passes through the block, and each slot has a fixed length, so there is no back-pressure path. A processor that needs the bus back removes the grant. The channel then parks at the next byte boundary with its request still raised, and resumes when the grant returns. The programmed count N moves N+1 bytes. A terminal-count flag records completion. The optional auto-initialise mode restores the address and count from shadow copies, so the same buffer can be served again without reprogramming.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `hold`, `dack`, `mem_en`, `mem_stb` and `tc_flag` are low and the channel is disarmed: `dreq` alone raises no `hold` until a count is written.
- R2: A write with `cfg_sel`=0 loads the base and current address; `cfg_sel`=1 loads the base and current count from the low CNT_W bits, clears `tc_flag` and arms the channel; `cfg_sel`=2 loads the mode (bit0 = decrement address, bit1 = auto-initialise, bit2 = device-to-memory direction).
- R3: `dreq` seen while idle and armed raises `hold` on the next cycle. `dack` and `mem_en` stay low while `hlda` is low, and the first slot starts in the cycle after `hlda` is sampled high.
- R4: Each byte takes exactly three `mem_en` cycles (address, strobe, release), with `mem_stb` high only in the middle one. `dack` is high in every `mem_en` cycle.
- R5: Each byte after the first uses the address one above (or, with mode bit0 set, one below) the previous byte's address, modulo 2^ADDR_W.
- R6: A programmed count N transfers N+1 bytes. In the cycle after the last slot, `hold`, `dack` and `mem_en` are all low.
- R7: `tc_flag` rises at the end of the last byte and stays high until the next count write.
- R8: Without auto-initialise, the channel disarms at terminal count (a later `dreq` raises no `hold`), and `mem_addr` holds start+(N+1) (or start-(N+1)).
- R9: With auto-initialise, terminal count reloads the current address and count from the base copies. `mem_addr` then shows the start address, and a new `dreq` repeats the same N+1-byte sequence with no reprogramming.
- R10: If `hlda` falls during a burst, the byte in progress completes. The channel then drops `mem_en` and `dack` while keeping `hold` high, and it resumes at the next address once `hlda` returns.
- R11: Configuration writes made while `hold` is high change neither the address, the count, the mode nor the armed state.
- R12: `mem_wr` equals mode bit2 in every `mem_en` cycle and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 mode |
| cfg_wdata | input | ADDR_W | Configuration write data |
| dreq | input | 1 | Device transfer request |
| hlda | input | 1 | Bus grant from the processor |
| hold | output | 1 | Bus request to the processor |
| dack | output | 1 | Acknowledge to the device while the channel owns the bus |
| mem_en | output | 1 | Channel drives the memory bus; address valid |
| mem_stb | output | 1 | Memory strobe, middle cycle of each slot |
| mem_wr | output | 1 | 1 = device-to-memory write, 0 = memory-to-device read |
| mem_addr | output | ADDR_W | Current address (bus value while `mem_en`) |
| tc_flag | output | 1 | Terminal count reached |

## Verification
The bench builds the block with ADDR_W=8 and CNT_W=4. That makes every count from 0 to 15 reachable, in both address directions and from start addresses next to 0 and 255, so address wrap in both directions is covered. With these sizes, bursts that stall on a late grant, park on a withdrawn grant, auto-reload, or receive writes during ownership all finish within a few dozen cycles.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADR,
    ST_STB,
    ST_REL
  } slot_st_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;

  typedef struct packed {
    logic to_mem;
    logic auto_ld;
    logic dec;
  } mode_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              busy,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last_byte,
  output logic              armed,
  output logic              tc_flag,
  output mode_t             mode
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] base_addr;
  logic [CNT_W-1:0]  base_cnt;
  logic [CNT_W-1:0]  cur_cnt;
  logic              wr_ok;
  logic              at_tc;

  assign wr_ok     = cfg_we && !busy;
  assign last_byte = (cur_cnt == '0);
  assign at_tc     = step && last_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
      armed     <= 1'b0;
      tc_flag   <= 1'b0;
    end else if (wr_ok) begin
      case (cfg_sel)
        SEL_ADDR: begin
          base_addr <= cfg_wdata;
          cur_addr  <= cfg_wdata;
        end
        SEL_CNT: begin
          base_cnt <= cfg_wdata[CNT_W-1:0];
          cur_cnt  <= cfg_wdata[CNT_W-1:0];
          armed    <= 1'b1;
          tc_flag  <= 1'b0;
        end
        SEL_MODE: mode <= cfg_wdata[2:0];
        default: ;
      endcase
    end else if (step) begin
      if (at_tc) begin
        tc_flag <= 1'b1;
        if (mode.auto_ld) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= mode.dec ? cur_addr - ADDR_ONE : cur_addr + ADDR_ONE;
          cur_cnt  <= cur_cnt - CNT_ONE;
          armed    <= 1'b0;
        end
      end else begin
        cur_addr <= mode.dec ? cur_addr - ADDR_ONE : cur_addr + ADDR_ONE;
        cur_cnt  <= cur_cnt - CNT_ONE;
      end
    end
  end

  a_r11_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy) |=> ($stable(base_addr) && $stable(base_cnt) && $stable(mode)));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last_byte) |=> (cur_cnt == $past(cur_cnt) - CNT_ONE));

  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_byte && mode.auto_ld) |=> (cur_addr == base_addr && cur_cnt == base_cnt && armed));

  a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_byte && !mode.auto_ld) |=> !armed);

  a_r7_tc_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> $past(step));
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic hlda,
  input  logic armed,
  input  logic last_byte,
  output logic hold,
  output logic own,
  output logic stb,
  output logic step
);
  slot_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (dreq && armed) st_d = ST_REQ;
      ST_REQ:  if (hlda) st_d = ST_ADR;
      ST_ADR:  st_d = ST_STB;
      ST_STB:  st_d = ST_REL;
      ST_REL: begin
        if (last_byte)  st_d = ST_IDLE;
        else if (hlda)  st_d = ST_ADR;
        else            st_d = ST_REQ;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign hold = (st_q != ST_IDLE);
  assign own  = (st_q == ST_ADR) || (st_q == ST_STB) || (st_q == ST_REL);
  assign stb  = (st_q == ST_STB);
  assign step = (st_q == ST_REL);

  a_r3_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own) |-> $past(hlda));

  a_r2_own_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    own |-> hold);

  a_r4_stb_framed: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (own && !stb));

  a_r6_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> ($past(step) && $past(last_byte)));

  a_r10_park_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $fell(own)) |-> ($past(step) && !$past(hlda)));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              dreq,
  input  logic              hlda,
  output logic              hold,
  output logic              dack,
  output logic              mem_en,
  output logic              mem_stb,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              tc_flag
);
  logic  own, stb, step, armed, last_byte;
  mode_t mode;

  dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (hold),
    .step      (step),
    .cur_addr  (mem_addr),
    .last_byte (last_byte),
    .armed     (armed),
    .tc_flag   (tc_flag),
    .mode      (mode)
  );

  dma_chan_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .dreq      (dreq),
    .hlda      (hlda),
    .armed     (armed),
    .last_byte (last_byte),
    .hold      (hold),
    .own       (own),
    .stb       (stb),
    .step      (step)
  );

  assign dack    = own;
  assign mem_en  = own;
  assign mem_stb = stb;
  assign mem_wr  = own && mode.to_mem;

  a_r12_dir_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_en && dack));
endmodule

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;
  localparam int AW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          dreq = 1'b0;
  logic          hlda = 1'b0;
  logic          hold, dack, mem_en, mem_stb, mem_wr, tc_flag;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int nbytes = 0;
  int en_cycles = 0;
  int drop_at = -1;
  bit grant_ok = 1'b1;
  bit dec_m = 1'b0;
  bit wr_exp = 1'b0;
  logic [AW-1:0] exp_addr = '0;

  always #4 clk = ~clk;

  dma_chan_seq #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dreq(dreq), .hlda(hlda), .hold(hold),
    .dack(dack), .mem_en(mem_en), .mem_stb(mem_stb), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .tc_flag(tc_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // processor model and bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_stb) begin
        chk(mem_addr == exp_addr, "R5", mem_addr, exp_addr);
        chk(mem_wr == wr_exp, "R12", mem_wr, wr_exp);
        exp_addr = dec_m ? exp_addr - 1'b1 : exp_addr + 1'b1;
        nbytes++;
        if (nbytes == drop_at) grant_ok = 1'b0;
      end
      if (mem_en) begin
        en_cycles++;
        chk(dack == 1'b1, "R4", dack, 1);
      end else if (mem_wr) begin
        chk(1'b0, "R12", mem_wr, 0);
      end
    end
    hlda <= hold && grant_ok;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_ch(input logic [AW-1:0] start, input int n, input bit dec, input bit au, input bit wr);
    cfg_write(2'd2, AW'({wr, au, dec}));   // R2: mode bits
    cfg_write(2'd0, start);
    cfg_write(2'd1, AW'(n));
  endtask

  task automatic wait_release();
    while (hold) @(negedge clk);
  endtask

  task automatic check_no_hold(input string req);
    dreq = 1'b1;
    repeat (3) @(negedge clk);
    chk(hold == 1'b0, req, hold, 0);
    dreq = 1'b0;
    @(negedge clk);
  endtask

  task automatic burst(input logic [AW-1:0] start, input int n, input bit dec, input bit wr);
    exp_addr = start; dec_m = dec; wr_exp = wr; nbytes = 0; en_cycles = 0;
    dreq = 1'b1;
    @(negedge clk);
    chk(hold == 1'b1 && dack == 1'b0, "R3", {hold, dack}, 2);
    dreq = 1'b0;
    wait_release();
    chk(nbytes == n + 1, "R6", nbytes, n + 1);
    chk(en_cycles == 3 * (n + 1), "R4", en_cycles, 3 * (n + 1));
    chk(dack == 1'b0 && mem_en == 1'b0, "R6", {dack, mem_en}, 0);
    chk(tc_flag == 1'b1, "R7", tc_flag, 1);
  endtask

  task automatic plain_xfer(input logic [AW-1:0] start, input int n, input bit dec, input bit wr);
    logic [AW-1:0] fin;
    program_ch(start, n, dec, 1'b0, wr);
    chk(tc_flag == 1'b0, "R2", tc_flag, 0);
    burst(start, n, dec, wr);
    fin = dec ? start - AW'(n + 1) : start + AW'(n + 1);
    chk(mem_addr == fin, "R8", mem_addr, fin);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and disarmed channel
    chk({hold, dack, mem_en, mem_stb, tc_flag} == 5'b0, "R1",
        {hold, dack, mem_en, mem_stb, tc_flag}, 0);
    check_no_hold("R1");

    // sweep: every count, both directions, starts near both ends
    foreach (sweep_starts[i]) begin
      for (int n = 0; n < 16; n++) begin
        for (int d = 0; d < 2; d++) begin
          plain_xfer(sweep_starts[i], n, d[0], n[0]);
        end
      end
    end
    // R8: disarmed after terminal count
    check_no_hold("R8");
    chk(tc_flag == 1'b1, "R7", tc_flag, 1);

    // R3: late grant keeps the bus untouched
    program_ch(8'h40, 2, 1'b0, 1'b0, 1'b1);
    grant_ok = 1'b0;
    exp_addr = 8'h40; dec_m = 1'b0; wr_exp = 1'b1; nbytes = 0; en_cycles = 0;
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(hold == 1'b1 && dack == 1'b0 && mem_en == 1'b0, "R3", {hold, dack, mem_en}, 4);
    end
    grant_ok = 1'b1;
    wait_release();
    chk(nbytes == 3, "R3", nbytes, 3);

    // R10: grant withdrawn mid-burst
    program_ch(8'hF8, 9, 1'b1, 1'b0, 1'b0);
    exp_addr = 8'hF8; dec_m = 1'b1; wr_exp = 1'b0; nbytes = 0; en_cycles = 0;
    drop_at = 4;
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    while (!(hold && !mem_en && nbytes > 0)) @(negedge clk);
    chk(nbytes == 4, "R10", nbytes, 4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(hold == 1'b1 && dack == 1'b0 && mem_en == 1'b0, "R10", {hold, dack, mem_en}, 4);
    end
    drop_at = -1;
    grant_ok = 1'b1;
    wait_release();
    chk(nbytes == 10, "R10", nbytes, 10);
    chk(en_cycles == 30, "R10", en_cycles, 30);

    // R9: auto-initialise reload and repeat
    program_ch(8'h20, 5, 1'b0, 1'b1, 1'b1);
    burst(8'h20, 5, 1'b0, 1'b1);
    chk(mem_addr == 8'h20, "R9", mem_addr, 8'h20);
    burst(8'h20, 5, 1'b0, 1'b1);
    chk(mem_addr == 8'h20, "R9", mem_addr, 8'h20);

    // R11: writes during ownership ignored
    program_ch(8'h80, 7, 1'b0, 1'b0, 1'b0);
    exp_addr = 8'h80; dec_m = 1'b0; wr_exp = 1'b0; nbytes = 0; en_cycles = 0;
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    cfg_write(2'd0, 8'h55);
    cfg_write(2'd1, 8'h03);
    cfg_write(2'd2, 8'h07);
    wait_release();
    chk(nbytes == 8, "R11", nbytes, 8);
    chk(mem_addr == 8'h88, "R11", mem_addr, 8'h88);
    check_no_hold("R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  logic [AW-1:0] sweep_starts [3] = '{8'h00, 8'h03, 8'hFE};
endmodule